// File: doc/BRIEF.md
# Low-Power Request and Wake Controller

This block holds the control register through which software asks the device to doze or to sleep, and decides when an incoming event ends that low-power period. Software sets a request bit through a single-register write port. The block then walks a small state machine. Doze is reached one cycle after the request is seen. Sleep passes through an entry phase of a configurable number of cycles before the asleep state is reached. The current state is driven on a dedicated output and is also readable through the register port.

Four event lines can end a low-power period: a normal interrupt, a critical interrupt, a debug event and a machine check. Two mask bits in the register can stop the first two from waking the device, whatever low-power state is active. The debug event and machine check ignore the masks. Any event that is not masked clears both request bits and returns the machine to full operation, even in the middle of sleep entry. The block never re-enters a low-power state by itself afterwards: software has to set a request bit again.

Top module: `lpwake_ctrl`

## Requirements
- R1: After reset, `reg_rdata` is zero and `lp_state` is 0 (run).
- R2: A write stores bit 0 (sleep request), bit 1 (doze request), bit 4 (normal-interrupt mask) and bit 5 (critical-interrupt mask). `reg_rdata` returns these at the same positions, returns the state on bits 9:8 (0 run, 1 entering sleep, 2 asleep, 3 dozing) and returns all other bits as zero.
- R3: With only the doze request set and no wake event, the state moves from run to dozing at the first clock edge after the request is stored.
- R4: With the sleep request set, the state is entering sleep for exactly ENTRY_CYC cycles and then becomes asleep.
- R5: When both request bits are set together, sleep wins and the state moves to entering sleep. Both bits stay readable as set.
- R6: An unmasked normal or critical interrupt clears both request bits and sets the state to run at the next clock edge. The mask bits are kept.
- R7: While the normal-interrupt mask is set, the normal interrupt changes neither the state nor the register.
- R8: While the critical-interrupt mask is set, the critical interrupt changes neither the state nor the register.
- R9: The masks act in the dozing state exactly as they do in the asleep state.
- R10: The debug event and the machine check wake the device and clear both request bits even when both masks are set.
- R11: An unmasked event during sleep entry aborts the entry: both request bits clear and the state is run at the next edge.
- R12: After a wake, the state stays run until software writes a request bit again.
- R13: When software clears the request bits while in a low-power state, the state returns to run at the next edge.
- R14: When a write and an unmasked event fall in the same cycle, the event wins: both request bits read back as zero and the masks take the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the control register |
| reg_wdata | input | DATA_W | Write data (request and mask fields) |
| reg_rdata | output | DATA_W | Register fields and current state |
| irq_in | input | 1 | Normal interrupt line (maskable) |
| crit_irq_in | input | 1 | Critical interrupt line (maskable) |
| dbg_evt_in | input | 1 | Debug event line (never masked) |
| mchk_in | input | 1 | Machine check line (never masked) |
| lp_state | output | 2 | Current state: 0 run, 1 entering sleep, 2 asleep, 3 dozing |

## Verification
A register write is visible on `reg_rdata` right after the edge that takes it. The state reacts one edge later: dozing or entering sleep one cycle after the request is stored, and asleep a further ENTRY_CYC cycles after that. A wake event held during one cycle clears the request bits and forces run at the same edge, so both results are due at the first edge after the event. The bench drives inputs on falling edges and samples on the falling edge after each expected change, counting cycles from the write or event that caused it.

// File: rtl/lpwake_pkg.sv
package lpwake_pkg;

   typedef enum logic [1:0] {
      LP_RUN    = 2'd0,
      LP_ENTER  = 2'd1,
      LP_ASLEEP = 2'd2,
      LP_DOZE   = 2'd3
   } lp_state_e;

   // register field positions
   localparam int FLD_SLEEP    = 0;
   localparam int FLD_DOZE     = 1;
   localparam int FLD_NMASK    = 4;
   localparam int FLD_CMASK    = 5;
   localparam int FLD_STATE_LO = 8;
   localparam int FLD_TOP      = FLD_STATE_LO + 2;

   // wake source indices
   localparam int NUM_SRC  = 4;
   localparam int SRC_IRQ  = 0;
   localparam int SRC_CRIT = 1;
   localparam int SRC_DBG  = 2;
   localparam int SRC_MCHK = 3;
   localparam logic [NUM_SRC-1:0] SRC_MASKABLE = 4'b0011;

   typedef struct packed {
      logic cmask;
      logic nmask;
      logic doze;
      logic sleep;
   } lp_ctl_t;

endpackage

// File: rtl/lpwake_filter.sv
module lpwake_filter
   import lpwake_pkg::*;
(
   input  logic [NUM_SRC-1:0] src,
   input  logic               nmask,
   input  logic               cmask,
   output logic               wake
);

   logic [NUM_SRC-1:0] mask_vec;
   logic [NUM_SRC-1:0] gated;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      if (i == SRC_IRQ) begin : g_n
         assign mask_vec[i] = nmask;
      end else if (i == SRC_CRIT) begin : g_c
         assign mask_vec[i] = cmask;
      end else begin : g_none
         assign mask_vec[i] = 1'b0;
      end

      if (SRC_MASKABLE[i]) begin : g_gate
         assign gated[i] = src[i] & ~mask_vec[i];
      end else begin : g_pass
         assign gated[i] = src[i];
      end
   end

   assign wake = |gated;

endmodule

// File: rtl/lpwake_regs.sv
module lpwake_regs
   import lpwake_pkg::*;
#(
   parameter int DATA_W = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wake,
   output lp_ctl_t           ctl
);

   logic unused_wbits;
   assign unused_wbits = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl <= '0;
      end else begin
         if (wr_en) begin
            ctl.sleep <= wdata[FLD_SLEEP];
            ctl.doze  <= wdata[FLD_DOZE];
            ctl.nmask <= wdata[FLD_NMASK];
            ctl.cmask <= wdata[FLD_CMASK];
         end
         if (wake) begin
            ctl.sleep <= 1'b0;
            ctl.doze  <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/lpwake_fsm.sv
module lpwake_fsm
   import lpwake_pkg::*;
#(
   parameter int ENTRY_CYC = 4
)(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sleep_req,
   input  logic      doze_req,
   input  logic      wake,
   output lp_state_e state
);

   lp_state_e nxt;
   logic      entry_done;

   always_comb begin
      nxt = state;
      if (wake) begin
         nxt = LP_RUN;
      end else begin
         unique case (state)
            LP_RUN: begin
               if (sleep_req)     nxt = LP_ENTER;
               else if (doze_req) nxt = LP_DOZE;
            end
            LP_ENTER: begin
               if (!sleep_req)      nxt = LP_RUN;
               else if (entry_done) nxt = LP_ASLEEP;
            end
            LP_ASLEEP: begin
               if (!sleep_req) nxt = LP_RUN;
            end
            LP_DOZE: begin
               if (sleep_req)     nxt = LP_ENTER;
               else if (!doze_req) nxt = LP_RUN;
            end
            default: nxt = LP_RUN;
         endcase
      end
   end

   if (ENTRY_CYC > 1) begin : g_cnt
      localparam int CNT_W = $clog2(ENTRY_CYC);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(ENTRY_CYC - 1);
      logic [CNT_W-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 cnt <= '0;
         else if (state == LP_ENTER && nxt == LP_ENTER) cnt <= cnt + 1'b1;
         else                                        cnt <= '0;
      end
      assign entry_done = (cnt == LAST);
   end else begin : g_single
      assign entry_done = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= LP_RUN;
      else        state <= nxt;
   end

endmodule

// File: rtl/lpwake_ctrl.sv
module lpwake_ctrl
   import lpwake_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int ENTRY_CYC = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              irq_in,
   input  logic              crit_irq_in,
   input  logic              dbg_evt_in,
   input  logic              mchk_in,
   output logic [1:0]        lp_state
);

   if (DATA_W < FLD_TOP) begin : g_bad_width
      $error("lpwake_ctrl: DATA_W too small for register fields");
   end
   if (ENTRY_CYC < 1) begin : g_bad_entry
      $error("lpwake_ctrl: ENTRY_CYC must be at least 1");
   end

   lp_ctl_t            ctl;
   lp_state_e          state;
   logic               wake;
   logic [NUM_SRC-1:0] src;

   always_comb begin
      src           = '0;
      src[SRC_IRQ]  = irq_in;
      src[SRC_CRIT] = crit_irq_in;
      src[SRC_DBG]  = dbg_evt_in;
      src[SRC_MCHK] = mchk_in;
   end

   lpwake_filter u_filter (
      .src   (src),
      .nmask (ctl.nmask),
      .cmask (ctl.cmask),
      .wake  (wake)
   );

   lpwake_regs #(.DATA_W(DATA_W)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (reg_wr_en),
      .wdata (reg_wdata),
      .wake  (wake),
      .ctl   (ctl)
   );

   lpwake_fsm #(.ENTRY_CYC(ENTRY_CYC)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .sleep_req (ctl.sleep),
      .doze_req  (ctl.doze),
      .wake      (wake),
      .state     (state)
   );

   always_comb begin
      reg_rdata                        = '0;
      reg_rdata[FLD_SLEEP]             = ctl.sleep;
      reg_rdata[FLD_DOZE]              = ctl.doze;
      reg_rdata[FLD_NMASK]             = ctl.nmask;
      reg_rdata[FLD_CMASK]             = ctl.cmask;
      reg_rdata[FLD_STATE_LO +: 2]     = state;
   end

   assign lp_state = state;

endmodule

// File: rtl/lpwake_chk.sv
module lpwake_chk
   import lpwake_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int ENTRY_CYC = 4
)(
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr_en,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              irq_in,
   input logic              crit_irq_in,
   input logic              dbg_evt_in,
   input logic              mchk_in,
   input logic [1:0]        lp_state
);

   logic        nm, cm, sreq, dreq, any_evt;
   logic [31:0] ent_run;
   logic [1:0]  prev_st;

   assign nm      = reg_rdata[FLD_NMASK];
   assign cm      = reg_rdata[FLD_CMASK];
   assign sreq    = reg_rdata[FLD_SLEEP];
   assign dreq    = reg_rdata[FLD_DOZE];
   assign any_evt = irq_in | crit_irq_in | dbg_evt_in | mchk_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent_run <= '0;
         prev_st <= LP_RUN;
      end else begin
         ent_run <= (lp_state == LP_ENTER) ? ent_run + 1 : '0;
         prev_st <= lp_state;
      end
   end

   // R6
   wake_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_in && !nm) || (crit_irq_in && !cm))
      |=> (lp_state == LP_RUN && reg_rdata[FLD_SLEEP] == 1'b0 && reg_rdata[FLD_DOZE] == 1'b0));

   // R10
   unmaskable_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_evt_in || mchk_in)
      |=> (lp_state == LP_RUN && reg_rdata[FLD_SLEEP] == 1'b0 && reg_rdata[FLD_DOZE] == 1'b0));

   // R7
   nmask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_state == LP_ASLEEP && sreq && nm && irq_in && !crit_irq_in && !dbg_evt_in
       && !mchk_in && !reg_wr_en)
      |=> lp_state == LP_ASLEEP);

   // R8
   cmask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_state == LP_DOZE && dreq && !sreq && cm && crit_irq_in && !irq_in && !dbg_evt_in
       && !mchk_in && !reg_wr_en)
      |=> lp_state == LP_DOZE);

   // R3
   doze_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_state == LP_RUN && dreq && !sreq && !any_evt)
      |=> lp_state == LP_DOZE);

   // R5
   sleep_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_state == LP_RUN && sreq && !any_evt)
      |=> lp_state == LP_ENTER);

   // R4
   enter_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_state == LP_ASLEEP && prev_st == LP_ENTER) |-> ent_run == 32'(ENTRY_CYC));

   // R4
   enter_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ent_run <= 32'(ENTRY_CYC));

   // R12
   stay_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_state == LP_RUN && !sreq && !dreq && !reg_wr_en) |=> lp_state == LP_RUN);

   // R13
   req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_state != LP_RUN && !sreq && !dreq) |=> lp_state == LP_RUN);

endmodule

bind lpwake_ctrl lpwake_chk #(.DATA_W(DATA_W), .ENTRY_CYC(ENTRY_CYC)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_wr_en   (reg_wr_en),
   .reg_rdata   (reg_rdata),
   .irq_in      (irq_in),
   .crit_irq_in (crit_irq_in),
   .dbg_evt_in  (dbg_evt_in),
   .mchk_in     (mchk_in),
   .lp_state    (lp_state)
);

// File: tb/lpwake_ctrl_bench.sv
module lpwake_ctrl_bench;

   localparam int DW = 16;
   localparam int EC = 4;
   localparam logic [1:0] S_RUN = 2'd0, S_ENT = 2'd1, S_SLP = 2'd2, S_DOZ = 2'd3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          irq = 1'b0, crit = 1'b0, dbg = 1'b0, mchk = 1'b0;
   logic [1:0]    st;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   lpwake_ctrl #(.DATA_W(DW), .ENTRY_CYC(EC)) u_lpwake_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_wr_en   (wr_en),
      .reg_wdata   (wdata),
      .reg_rdata   (rdata),
      .irq_in      (irq),
      .crit_irq_in (crit),
      .dbg_evt_in  (dbg),
      .mchk_in     (mchk),
      .lp_state    (st)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // register field view: bits 5:0 plus state on 9:8
   function automatic logic [31:0] rd_exp(input logic [5:0] fld, input logic [1:0] s);
      return {22'd0, s, 2'b00, fld};
   endfunction

   task automatic wr(input logic [DW-1:0] d);
      @(negedge clk); wr_en = 1'b1; wdata = d;
      @(negedge clk); wr_en = 1'b0; wdata = '0;
   endtask

   task automatic pulse(input int which);
      @(negedge clk);
      case (which)
         0: irq = 1'b1;
         1: crit = 1'b1;
         2: dbg = 1'b1;
         default: mchk = 1'b1;
      endcase
      @(negedge clk);
      irq = 1'b0; crit = 1'b0; dbg = 1'b0; mchk = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R1 rdata", 32'(rdata), 32'h0);
      chk("R1 state", 32'(st), 32'(S_RUN));
   endtask

   task automatic t_readback;
      wr(16'h0030);
      chk("R2 masks readback", 32'(rdata), rd_exp(6'h30, S_RUN));
      wr(16'hFFCC);
      chk("R2 unused bits zero", 32'(rdata), rd_exp(6'h00, S_RUN));
      wr(16'h0000);
   endtask

   task automatic t_doze;
      wr(16'h0002);
      chk("R3 request stored, still run", 32'(rdata), rd_exp(6'h02, S_RUN));
      @(negedge clk);
      chk("R3 dozing after one edge", 32'(st), 32'(S_DOZ));
      idle(3);
      chk("R3 doze held", 32'(st), 32'(S_DOZ));
      pulse(0);
      chk("R6 irq wakes doze", 32'(rdata), rd_exp(6'h00, S_RUN));
      idle(6);
      chk("R12 no re-entry", 32'(rdata), rd_exp(6'h00, S_RUN));
   endtask

   task automatic t_sleep;
      wr(16'h0001);
      for (int k = 1; k <= EC; k++) begin
         @(negedge clk);
         chk("R4 entering", 32'(st), 32'(S_ENT));
      end
      @(negedge clk);
      chk("R4 asleep after entry", 32'(st), 32'(S_SLP));
      idle(2);
      chk("R4 asleep held", 32'(rdata), rd_exp(6'h01, S_SLP));
      pulse(1);
      chk("R6 crit wakes sleep", 32'(rdata), rd_exp(6'h00, S_RUN));
   endtask

   task automatic t_both;
      wr(16'h0003);
      @(negedge clk);
      chk("R5 sleep wins", 32'(rdata), rd_exp(6'h03, S_ENT));
      wr(16'h0000);
      @(negedge clk);
      chk("R13 software clear returns to run", 32'(st), 32'(S_RUN));
   endtask

   task automatic t_nmask;
      wr(16'h0011);
      idle(EC + 1);
      chk("R7 asleep with nmask", 32'(st), 32'(S_SLP));
      pulse(0);
      chk("R7 masked irq ignored", 32'(rdata), rd_exp(6'h11, S_SLP));
      pulse(1);
      chk("R6 crit wakes, masks kept", 32'(rdata), rd_exp(6'h10, S_RUN));
   endtask

   task automatic t_cmask_doze;
      wr(16'h0022);
      @(negedge clk);
      chk("R8 dozing with cmask", 32'(st), 32'(S_DOZ));
      pulse(1);
      chk("R8 masked crit ignored", 32'(rdata), rd_exp(6'h22, S_DOZ));
      pulse(0);
      chk("R6 irq wakes doze", 32'(rdata), rd_exp(6'h20, S_RUN));
      wr(16'h0032);
      @(negedge clk);
      pulse(0);
      chk("R9 nmask holds in doze", 32'(rdata), rd_exp(6'h32, S_DOZ));
      pulse(1);
      chk("R9 cmask holds in doze", 32'(rdata), rd_exp(6'h32, S_DOZ));
   endtask

   task automatic t_unmaskable;
      pulse(2);
      chk("R10 debug wakes despite masks", 32'(rdata), rd_exp(6'h30, S_RUN));
      wr(16'h0031);
      idle(EC + 1);
      chk("R10 asleep with both masks", 32'(st), 32'(S_SLP));
      pulse(0);
      pulse(1);
      chk("R9 masks hold in sleep", 32'(rdata), rd_exp(6'h31, S_SLP));
      pulse(3);
      chk("R10 machine check wakes", 32'(rdata), rd_exp(6'h30, S_RUN));
      wr(16'h0000);
   endtask

   task automatic t_abort;
      wr(16'h0001);
      idle(2);
      chk("R11 in entry", 32'(st), 32'(S_ENT));
      pulse(0);
      chk("R11 entry aborted", 32'(rdata), rd_exp(6'h00, S_RUN));
      idle(EC + 2);
      chk("R12 stays run after abort", 32'(st), 32'(S_RUN));
   endtask

   task automatic t_same_cycle;
      @(negedge clk);
      wr_en = 1'b1; wdata = 16'h0013; irq = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0; irq = 1'b0;
      chk("R14 event beats write", 32'(rdata), rd_exp(6'h10, S_RUN));
      @(negedge clk);
      chk("R14 still run", 32'(st), 32'(S_RUN));
   endtask

   task automatic finish_run;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(4 * 100000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog (R1..): actual hung expected finished");
         finish_run();
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_readback();
      t_doze();
      t_sleep();
      t_both();
      t_nmask();
      t_cmask_doze();
      t_unmaskable();
      t_abort();
      t_same_cycle();
      done = 1'b1;
      finish_run();
   end

endmodule